// File: doc/BRIEF.md
# Two-Bank SDRAM Precharge and Read-Burst Tracker

This block sits on the controller side of a two-bank synchronous DRAM and watches every command the controller issues. The commands are no-operation, activate, read and precharge, each with a bank-select bit and an all-banks bit. For each bank it keeps a state that is open, precharging or idle. Two per-bank down-counters hold the minimum time from activate to precharge and the recovery time after a precharge. A command that breaks these rules is rejected: it changes no bank state and it sets a sticky protocol-error flag.

The block also works out, from the read commands and the selected CAS latency, which clock cycles carry valid read data. It drives a data-valid strobe and a bus output-enable from these cycles. A precharge that reaches the bank of a running burst stops the burst. Words already launched still arrive, and nothing is valid from the latency-th cycle after the precharge onward. The block is meant to feed the capture logic of a memory controller and its protocol monitors.

Top module: `sdram_bank_tracker`

## Requirements
- R1: When reset (synchronous, active high) is released, `bank_idle_o` is 2'b11 and `bank_open_o` is 2'b00. `rd_valid_o`, `rd_oe_o` and `proto_err_o` are all low.
- R2: The command code is 0 for no-op, 1 for activate, 2 for read and 3 for precharge. An activate in cycle c to an idle bank selected by `bank_i` (bit b of the bank vectors) sets `bank_open_o[b]` from cycle c+1.
- R3: A precharge with `all_i` low closes only the bank selected by `bank_i`. It is accepted in cycle a+TRAS or later after that bank's activate in cycle a. An earlier precharge is rejected.
- R4: After an accepted precharge in cycle p, `bank_idle_o` for that bank is low until cycle p+TRP-1 and high from cycle p+TRP. An activate to that bank before cycle p+TRP is rejected.
- R5: A precharge with `all_i` high ignores `bank_i` and closes both banks. It is rejected as a whole if either open bank has not yet met its activate-to-precharge time.
- R6: A rejected command changes no bank state. A read to a bank that is not open is rejected and produces no valid data.
- R7: A rejected command sets `proto_err_o` from the next cycle, and the flag stays set until reset.
- R8: With latency L (L=2 when `cl3_i` is 0, L=3 when it is 1), an accepted read in cycle c raises `rd_valid_o` in cycles c+L through c+L+BURST_LEN-1.
- R9: An accepted precharge in cycle p that covers the bank of the running burst, either by its bank bit or by `all_i`, removes every valid word from cycle p+L onward. Words before that cycle are kept. A precharge to the other bank leaves the burst whole.
- R10: `rd_oe_o` is high in exactly those cycles where `rd_valid_o` is high in the same cycle or in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Issued command: 0 no-op, 1 activate, 2 read, 3 precharge |
| bank_i | input | 1 | Bank addressed by the command |
| all_i | input | 1 | Precharge applies to both banks |
| cl3_i | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 (hold stable during bursts) |
| bank_open_o | output | 2 | Per-bank open (row active) state |
| bank_idle_o | output | 2 | Per-bank ready to accept an activate |
| rd_valid_o | output | 1 | Read data valid in this cycle |
| rd_oe_o | output | 1 | Data bus enable, one cycle ahead of and through valid data |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
The hardest case to reach is a truncated burst. The interrupting precharge must be legal, so the activate-to-precharge time of the read bank has to be met before the read starts. The precharge must then land inside the burst, at a chosen offset, under each latency setting. Each burst scenario therefore opens both banks and waits out that time, then issues the read. It places the precharge at a fixed offset, or aims it at the other bank, or uses the all-banks bit with the bank bit pointed away. It records the strobe and the enable over sixteen cycles and compares both traces with the traces worked out from the latency and the cutoff.

// File: rtl/sdrtrk_pkg.sv
package sdrtrk_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2
  } bank_st_e;

  // Tap of the launch pipeline that is due in the current cycle.
  function automatic logic due_tap(input logic [2:0] sr, input logic cl3);
    return cl3 ? sr[2] : sr[1];
  endfunction

  // Tap that becomes due in the next cycle.
  function automatic logic next_tap(input logic [2:0] sr, input logic cl3);
    return cl3 ? sr[1] : sr[0];
  endfunction

  // Bank mask addressed by a command.
  function automatic logic [1:0] bank_mask(input logic bank, input logic all_pre);
    if (all_pre) return 2'b11;
    return bank ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/sdrtrk_bank.sv
module sdrtrk_bank
  import sdrtrk_pkg::*;
#(
  parameter int TRAS = 5,
  parameter int TRP  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic act_go_i,
  input  logic pre_go_i,
  output logic open_o,
  output logic ready_o,
  output logic ras_ok_o
);
  localparam int MAXT = (TRAS > TRP) ? TRAS : TRP;
  localparam int CW   = $clog2(MAXT + 1);

  bank_st_e        st_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        BK_IDLE: begin
          if (act_go_i) begin
            st_q  <= BK_OPEN;
            cnt_q <= CW'(TRAS - 1);
          end
        end
        BK_OPEN: begin
          if (pre_go_i) begin
            st_q  <= BK_PRECH;
            cnt_q <= CW'(TRP - 1);
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        BK_PRECH: begin
          if (act_go_i) begin
            st_q  <= BK_OPEN;
            cnt_q <= CW'(TRAS - 1);
          end else if (cnt_q == '0) begin
            st_q  <= BK_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  assign open_o   = (st_q == BK_OPEN);
  assign ready_o  = (st_q == BK_IDLE) || ((st_q == BK_PRECH) && (cnt_q == '0));
  assign ras_ok_o = (st_q == BK_OPEN) && (cnt_q == '0);

  // R3
  ras_before_close_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(open_o) |-> $past(ras_ok_o));

  // R4
  open_from_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(ready_o));

endmodule

// File: rtl/sdrtrk_rdpipe.sv
module sdrtrk_rdpipe
  import sdrtrk_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cut_i,
  input  logic cl3_i,
  output logic valid_o,
  output logic oe_o
);
  localparam int MAX_CL = 3;
  localparam int GW     = $clog2(BURST_LEN);

  logic [GW-1:0]     gen_cnt_q;
  logic [MAX_CL-1:0] sr_q;
  logic              launch;

  // A word leaves the command side this cycle.
  assign launch = start_i || ((gen_cnt_q != '0) && !cut_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_cnt_q <= '0;
      sr_q      <= '0;
    end else begin
      sr_q <= {sr_q[MAX_CL-2:0], launch};
      if (start_i)
        gen_cnt_q <= GW'(BURST_LEN - 1);
      else if (cut_i)
        gen_cnt_q <= '0;
      else if (gen_cnt_q != '0)
        gen_cnt_q <= gen_cnt_q - 1'b1;
    end
  end

  assign valid_o = due_tap(sr_q, cl3_i);
  assign oe_o    = due_tap(sr_q, cl3_i) | next_tap(sr_q, cl3_i);

  // R9
  cut_stops_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (cut_i && !start_i) |=> (gen_cnt_q == '0));

  // R10
  oe_covers_valid_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> oe_o);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdrtrk_pkg::*;
#(
  parameter int TRAS      = 5,
  parameter int TRP       = 3,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cmd_i,
  input  logic       bank_i,
  input  logic       all_i,
  input  logic       cl3_i,
  output logic [1:0] bank_open_o,
  output logic [1:0] bank_idle_o,
  output logic       rd_valid_o,
  output logic       rd_oe_o,
  output logic       proto_err_o
);
  localparam int NBANK = 2;

  cmd_e             cmd;
  logic [NBANK-1:0] tgt, ras_ok, act_go, pre_go;
  logic             act_bad, rd_bad, pre_bad, cmd_bad;
  logic             rd_go, pre_ok, cut;
  logic             rd_bank_q, err_q;

  assign cmd = cmd_e'(cmd_i);
  assign tgt = bank_mask(bank_i, (cmd == CMD_PRE) && all_i);

  assign act_bad = (cmd == CMD_ACT) && !bank_idle_o[bank_i];
  assign rd_bad  = (cmd == CMD_RD)  && !bank_open_o[bank_i];
  assign pre_bad = (cmd == CMD_PRE) && |(tgt & bank_open_o & ~ras_ok);
  assign cmd_bad = act_bad | rd_bad | pre_bad;

  assign rd_go  = (cmd == CMD_RD)  && !cmd_bad;
  assign pre_ok = (cmd == CMD_PRE) && !cmd_bad;
  assign cut    = pre_ok && tgt[rd_bank_q];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_go[b] = (cmd == CMD_ACT) && !cmd_bad && tgt[b];
    assign pre_go[b] = pre_ok && tgt[b];

    sdrtrk_bank #(.TRAS(TRAS), .TRP(TRP)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .act_go_i (act_go[b]),
      .pre_go_i (pre_go[b]),
      .open_o   (bank_open_o[b]),
      .ready_o  (bank_idle_o[b]),
      .ras_ok_o (ras_ok[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (rd_go)   rd_bank_q <= bank_i;
      if (cmd_bad) err_q     <= 1'b1;
    end
  end

  assign proto_err_o = err_q;

  sdrtrk_rdpipe #(.BURST_LEN(BURST_LEN)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .start_i (rd_go),
    .cut_i   (cut),
    .cl3_i   (cl3_i),
    .valid_o (rd_valid_o),
    .oe_o    (rd_oe_o)
  );

  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_bad |=> $stable(bank_open_o));

  // R5
  all_close_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_ok && all_i) |=> (bank_open_o == 2'b00));

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> proto_err_o);

  // R7
  err_after_reject_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_bad |=> proto_err_o);

endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;
  localparam int TRAS = 5;
  localparam int TRP  = 3;
  localparam int BL   = 4;
  localparam int NOPC = 0, ACTC = 1, RDC = 2, PREC = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd_i = 2'd0;
  logic       bank_i = 1'b0, all_i = 1'b0, cl3_i = 1'b0;
  logic [1:0] bank_open_o, bank_idle_o;
  logic       rd_valid_o, rd_oe_o, proto_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_bank_tracker #(.TRAS(TRAS), .TRP(TRP), .BURST_LEN(BL)) u_sdram_bank_tracker (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .all_i(all_i),
    .cl3_i(cl3_i), .bank_open_o(bank_open_o), .bank_idle_o(bank_idle_o),
    .rd_valid_o(rd_valid_o), .rd_oe_o(rd_oe_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive the command for the current cycle; outputs then show this cycle.
  task automatic step(input int c, input logic b, input logic a);
    @(negedge clk);
    cmd_i = c[1:0]; bank_i = b; all_i = a;
    #1;
  endtask

  task automatic do_reset(input logic cl3);
    @(negedge clk);
    rst = 1'b1; cmd_i = 2'd0; bank_i = 1'b0; all_i = 1'b0; cl3_i = cl3;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    step(NOPC, 0, 0);
    chk("R1 idle", bank_idle_o, 3);
    chk("R1 open", bank_open_o, 0);
    chk("R1 valid/oe", {rd_valid_o, rd_oe_o}, 0);
    chk("R1 err", proto_err_o, 0);
  endtask

  task automatic t_bank_timing();
    do_reset(1'b0);
    step(ACTC, 0, 0);
    step(NOPC, 0, 0);
    chk("R2 open after act", bank_open_o, 1);
    for (int k = 2; k < TRAS; k++) step(NOPC, 0, 0);
    step(PREC, 0, 0);
    step(NOPC, 0, 0);
    chk("R3 closed at tRAS", bank_open_o, 0);
    chk("R3 no err", proto_err_o, 0);
    for (int k = 2; k < TRP; k++) step(NOPC, 0, 0);
    chk("R4 not idle before tRP", bank_idle_o[0], 0);
    step(NOPC, 0, 0);
    chk("R4 idle at tRP", bank_idle_o[0], 1);
  endtask

  task automatic t_early_pre();
    do_reset(1'b0);
    step(ACTC, 0, 0);
    for (int k = 1; k < TRAS - 1; k++) step(NOPC, 0, 0);
    step(PREC, 0, 0);
    step(NOPC, 0, 0);
    chk("R3 early pre err", proto_err_o, 1);
    chk("R6 bank stays open", bank_open_o, 1);
    step(NOPC, 0, 0);
    step(NOPC, 0, 0);
    chk("R7 err sticky", proto_err_o, 1);
  endtask

  task automatic t_early_act();
    do_reset(1'b0);
    step(ACTC, 0, 0);
    for (int k = 1; k < TRAS; k++) step(NOPC, 0, 0);
    step(PREC, 0, 0);
    for (int k = 1; k < TRP - 1; k++) step(NOPC, 0, 0);
    step(ACTC, 0, 0);
    step(NOPC, 0, 0);
    chk("R4 early act err", proto_err_o, 1);
    chk("R6 early act no open", bank_open_o, 0);
  endtask

  task automatic t_all_pre();
    do_reset(1'b0);
    step(ACTC, 0, 0);
    step(ACTC, 1, 0);
    for (int k = 0; k < TRAS; k++) step(NOPC, 0, 0);
    chk("R2 both open", bank_open_o, 3);
    step(PREC, 1, 1);
    step(NOPC, 0, 0);
    chk("R5 all closed", bank_open_o, 0);
    chk("R5 all no err", proto_err_o, 0);
    do_reset(1'b0);
    step(ACTC, 0, 0);
    for (int k = 1; k < TRAS; k++) step(NOPC, 0, 0);
    step(ACTC, 1, 0);
    step(PREC, 0, 1);
    step(NOPC, 0, 0);
    chk("R5 all rejected open", bank_open_o, 3);
    chk("R5 all rejected err", proto_err_o, 1);
  endtask

  // Read on bank 0 at j=0; optional precharge at j=pre_at.
  task automatic t_burst(input string tag, input logic cl3, input int pre_at,
                         input logic pb, input logic pa);
    logic [15:0] v, o, ev, eo;
    int lat, nw;
    do_reset(cl3);
    step(ACTC, 0, 0);
    step(ACTC, 1, 0);
    for (int k = 0; k < TRAS + 1; k++) step(NOPC, 0, 0);
    for (int j = 0; j < 16; j++) begin
      if (j == 0) step(RDC, 0, 0);
      else if (j == pre_at) step(PREC, pb, pa);
      else step(NOPC, 0, 0);
      v[j] = rd_valid_o;
      o[j] = rd_oe_o;
    end
    lat = cl3 ? 3 : 2;
    nw = BL;
    if (pre_at > 0 && (pa || pb == 1'b0) && pre_at < BL) nw = pre_at;
    ev = '0;
    for (int j = 0; j < 16; j++) ev[j] = (j >= lat) && (j < lat + nw);
    for (int j = 0; j < 16; j++) eo[j] = ev[j] | ((j < 15) ? ev[j+1] : 1'b0);
    chk({tag, " valid trace"}, int'(v), int'(ev));
    chk({"R10 oe trace ", tag}, int'(o), int'(eo));
    chk({tag, " no err"}, proto_err_o, 0);
  endtask

  task automatic t_bad_read();
    logic [15:0] v;
    do_reset(1'b1);
    for (int j = 0; j < 8; j++) begin
      step((j == 0) ? RDC : NOPC, 0, 0);
      v[j] = rd_valid_o;
    end
    chk("R6 read closed no data", int'(v[7:0]), 0);
    chk("R7 read closed err", proto_err_o, 1);
  endtask

  initial begin
    t_reset();
    t_bank_timing();
    t_early_pre();
    t_early_act();
    t_all_pre();
    t_burst("R8 cl2 full", 1'b0, -1, 1'b0, 1'b0);
    t_burst("R8 cl3 full", 1'b1, -1, 1'b0, 1'b0);
    t_burst("R9 cl3 cut at 2", 1'b1, 2, 1'b0, 1'b0);
    t_burst("R9 cl2 cut at 1", 1'b0, 1, 1'b0, 1'b0);
    t_burst("R5 R9 all cut at 3", 1'b1, 3, 1'b1, 1'b1);
    t_burst("R9 other bank kept", 1'b1, 1, 1'b1, 1'b0);
    t_bad_read();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule